// File: doc/BRIEF.md
# Serial Display Link PLL Start-up Controller

This block holds the configuration of a serial display link and its PLL, and runs the start-up handshake that software uses to bring the link up. Software programs a link configuration register (pixel clock divider, number of data pairs, bandwidth setting) and a PLL configuration register (frequency range, N and M dividers, a reset-release bit and a go bit) over a simple synchronous write port with a combinational read port. A third register is read-only and reports handshake status.

Start-up runs in this order. Software releases the PLL reset and sets the go bit. The controller raises a pending flag and then drops it on its own after a short fixed delay. Software then clears the go bit. A built-in lock counter models the analog PLL and raises the lock flag a programmable number of cycles later. Once the downstream LCD-enable input is high, the link-ready flag follows. Dropping the reset-release bit at any time abandons the sequence.

Top module: `sdlink_pll_ctrl`

## Requirements
- R1: After reset, the link configuration register (offset 0x44), the PLL configuration register (offset 0x48) and the status register (offset 0x5C) all read 0.
- R2: The link configuration register keeps the pixel divider in bits 19:15, the data-pair select in bits 3:2 (pairs minus one) and the bandwidth select in bits 1:0. All other bits read 0.
- R3: A write to the link configuration register whose bits 3:2 equal 3 leaves the pair select unchanged, while its other fields still take the written values. The pair select therefore only ever holds 0, 1 or 2.
- R4: The PLL configuration register keeps the go bit in bit 28, the frequency select in bits 25:22, the reset-release bit in bit 18, the N divider in bits 16:11 and the M divider in bits 10:1. All other bits read 0.
- R5: Writes to the status register or to any unmapped offset change no register. Reads of unmapped offsets return 0.
- R6: With reset-release at 1, a go bit of 1 makes status bit 6 (pending) read 1 from the cycle after the write. Pending drops by itself after ACK_CYCLES cycles.
- R7: After pending has dropped, a write that clears the go bit makes status bit 5 (lock) read 1 exactly LOCK_CYCLES+1 clock edges after that write, and not earlier.
- R8: Status bit 2 (link ready) is set one clock edge after a cycle in which lock is set and the LCD-enable input is high. It never reads 1 before lock.
- R9: While reset-release is 0, status bits 6, 5 and 2 read 0, and the sequence returns to idle at the next edge. Setting reset-release again without a new go request does not restart it.
- R10: A go bit of 1 written while reset-release is 0 starts nothing. Pending stays 0 until reset-release is also 1.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lcd_en | input | 1 | Downstream LCD-enable indication |

## Verification
The hardest condition to reach is an abort from the middle of the lock count when the LCD-enable input is already high. In that case lock must not appear, link ready must not appear, and a later reset-release without a fresh go request must not restart the sequence. The bench reaches this state directly. It raises LCD-enable first, completes the go phase, clears go, waits half the lock count, and then drops reset-release. It then holds the block idle longer than a full lock interval. Lock and ready timing are sampled at the exact edges derived from the handshake, one edge before and one edge after each expected transition.

// File: rtl/sdlink_pkg.sv
package sdlink_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LINK   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_PLL    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h5C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_WAIT_CLR,
    ST_LOCKING,
    ST_LOCKED,
    ST_LINKUP
  } seq_state_e;

  typedef struct packed {
    logic [4:0] pdiv;
    logic [1:0] pair;
    logic [1:0] bw;
  } link_cfg_t;

  typedef struct packed {
    logic       go;
    logic [3:0] freq;
    logic       rel;
    logic [5:0] ndiv;
    logic [9:0] mdiv;
  } pll_cfg_t;

  // Place link fields at their bus bit positions.
  function automatic logic [DATA_W-1:0] pack_link(input link_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[19:15] = c.pdiv;
    w[3:2]   = c.pair;
    w[1:0]   = c.bw;
    return w;
  endfunction

  // Place PLL fields at their bus bit positions.
  function automatic logic [DATA_W-1:0] pack_pll(input pll_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[28]    = c.go;
    w[25:22] = c.freq;
    w[18]    = c.rel;
    w[16:11] = c.ndiv;
    w[10:1]  = c.mdiv;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic pend,
                                                    input logic lock,
                                                    input logic ready);
    logic [DATA_W-1:0] w;
    w = '0;
    w[6] = pend;
    w[5] = lock;
    w[2] = ready;
    return w;
  endfunction

  // Pair select value 3 is not a legal pair count and is dropped.
  function automatic logic pair_legal(input logic [1:0] p);
    return p != 2'b11;
  endfunction

endpackage

// File: rtl/sdlink_regs.sv
module sdlink_regs
  import sdlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              st_pend,
  input  logic              st_lock,
  input  logic              st_ready,
  output logic [DATA_W-1:0] rdata,
  output link_cfg_t         link_q,
  output pll_cfg_t          pll_q
);

  logic hit_link, hit_pll, hit_status, hit_none;

  assign hit_link   = (addr == OFS_LINK);
  assign hit_pll    = (addr == OFS_PLL);
  assign hit_status = (addr == OFS_STATUS);
  assign hit_none   = !(hit_link || hit_pll || hit_status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= '0;
      pll_q  <= '0;
    end else if (wr_en) begin
      if (hit_link) begin
        link_q.pdiv <= wdata[19:15];
        link_q.bw   <= wdata[1:0];
        if (pair_legal(wdata[3:2])) link_q.pair <= wdata[3:2];
      end
      if (hit_pll) begin
        pll_q.go   <= wdata[28];
        pll_q.freq <= wdata[25:22];
        pll_q.rel  <= wdata[18];
        pll_q.ndiv <= wdata[16:11];
        pll_q.mdiv <= wdata[10:1];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_link)   rdata = pack_link(link_q);
    if (hit_pll)    rdata = pack_pll(pll_q);
    if (hit_status) rdata = pack_status(st_pend, st_lock, st_ready);
  end

  p_pair_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_q.pair != 2'b11);

  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |-> rdata == '0);

  p_status_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_link && !hit_pll) |=> $stable(link_q) && $stable(pll_q));

endmodule

// File: rtl/sdlink_seq.sv
module sdlink_seq
  import sdlink_pkg::*;
#(
  parameter int ACK_CYCLES  = 2,
  parameter int LOCK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic rel,
  input  logic lcd_en,
  output logic pending,
  output logic locked,
  output logic link_ready
);

  localparam int CNT_MAX = (ACK_CYCLES > LOCK_CYCLES) ? ACK_CYCLES : LOCK_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(ACK_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  // Named events for assertions and readability.
  logic go_seen, ack_done, lock_done, abort;
  assign abort     = !rel;
  assign go_seen   = (state == ST_IDLE)    && go;
  assign ack_done  = (state == ST_PEND)    && (cnt == ACK_LAST);
  assign lock_done = (state == ST_LOCKING) && (cnt == LOCK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go_seen) begin
          state <= ST_PEND;
          cnt   <= '0;
        end
        ST_PEND: if (ack_done) begin
          state <= ST_WAIT_CLR;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_WAIT_CLR: if (!go) begin
          state <= ST_LOCKING;
          cnt   <= '0;
        end
        ST_LOCKING: if (lock_done) begin
          state <= ST_LOCKED;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_LOCKED: if (lcd_en) state <= ST_LINKUP;
        ST_LINKUP: state <= ST_LINKUP;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // Reset-release low clears every flag at once.
  assign pending    = rel && (state == ST_PEND);
  assign locked     = rel && ((state == ST_LOCKED) || (state == ST_LINKUP));
  assign link_ready = rel && (state == ST_LINKUP);

  p_pend_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> cnt <= ACK_LAST);

  p_lock_after_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state == ST_LOCKING) && $past(cnt) == LOCK_LAST);

  p_ready_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(locked) && $past(lcd_en));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> state == ST_IDLE);

  p_start_needs_rel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(rel) && $past(go));

endmodule

// File: rtl/sdlink_pll_ctrl.sv
module sdlink_pll_ctrl
  import sdlink_pkg::*;
#(
  parameter int ACK_CYCLES  = 2,
  parameter int LOCK_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        lcd_en
);

  link_cfg_t link_q;
  pll_cfg_t  pll_q;
  logic      st_pend, st_lock, st_ready;

  sdlink_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .st_pend  (st_pend),
    .st_lock  (st_lock),
    .st_ready (st_ready),
    .rdata    (bus_rdata),
    .link_q   (link_q),
    .pll_q    (pll_q)
  );

  sdlink_seq #(
    .ACK_CYCLES  (ACK_CYCLES),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (pll_q.go),
    .rel        (pll_q.rel),
    .lcd_en     (lcd_en),
    .pending    (st_pend),
    .locked     (st_lock),
    .link_ready (st_ready)
  );

endmodule

// File: tb/tb_sdlink_pll_ctrl.sv
module tb_sdlink_pll_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ACK  = 2;
  localparam int LOCK = 24;

  localparam logic [31:0] GO  = 32'h1000_0000;
  localparam logic [31:0] REL = 32'h0004_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        lcd_en = 0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdlink_pll_ctrl #(.ACK_CYCLES(ACK), .LOCK_CYCLES(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_en(lcd_en)
  );

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h44, 32'h0007_800B, 8'h44, 32'h0007_800B},  // R2 all link fields
    '{8'h44, 32'hFFFF_FFFF, 8'h44, 32'h000F_800B},  // R3 pair 3 dropped
    '{8'h44, 32'h0000_0004, 8'h44, 32'h0000_0004},  // R3 pair 1 taken
    '{8'h48, 32'h01C0_5968, 8'h48, 32'h01C0_5968},  // R4 PLL fields
    '{8'h48, 32'hEFFB_FFFF, 8'h48, 32'h03C1_FFFE},  // R4 unused bits 0
    '{8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000},  // R5 unmapped read
    '{8'h5C, 32'hFFFF_FFFF, 8'h5C, 32'h0000_0000},  // R5 status write
    '{8'h50, 32'h1234_5678, 8'h44, 32'h0000_0004},  // R5 link untouched
    '{8'h4C, 32'hFFFF_FFFF, 8'h48, 32'h03C1_FFFE}   // R5 PLL untouched
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] got;
    rd(a, got);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk("R1 link", 8'h44, 0);
    chk("R1 pll", 8'h48, 0);
    chk("R1 status", 8'h5C, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].waddr, VEC[i].wdata);
      chk("R2-table", VEC[i].raddr, VEC[i].exp);
    end
    wr(8'h48, 0);

    // Full bring-up with LCD enable arriving late
    wr(8'h48, REL | GO);
    chk("R6 not yet pending", 8'h5C, 0);
    cyc(1);
    chk("R6 pending", 8'h5C, 32'h40);
    cyc(ACK);
    chk("R6 pending cleared", 8'h5C, 0);
    wr(8'h48, REL);
    cyc(LOCK);
    chk("R7 lock not early", 8'h5C, 0);
    cyc(1);
    chk("R7 lock", 8'h5C, 32'h20);
    cyc(5);
    chk("R8 no ready without lcd_en", 8'h5C, 32'h20);
    lcd_en = 1;
    cyc(1);
    chk("R8 ready", 8'h5C, 32'h24);
    wr(8'h48, 0);
    chk("R9 flags cleared", 8'h5C, 0);

    // Go with reset held, then an aborted lock with lcd_en already high
    wr(8'h48, GO);
    cyc(4);
    chk("R10 no start", 8'h5C, 0);
    wr(8'h48, REL | GO);
    cyc(1);
    chk("R10 start once released", 8'h5C, 32'h40);
    cyc(ACK);
    wr(8'h48, REL);
    cyc(LOCK/2);
    chk("R8 no ready before lock", 8'h5C, 0);
    wr(8'h48, 0);
    chk("R9 abort mid-lock", 8'h5C, 0);
    wr(8'h48, REL);
    cyc(LOCK + 4);
    chk("R9 no restart", 8'h5C, 0);

    // Clean restart with lcd_en high from the start
    wr(8'h48, REL | GO);
    cyc(ACK + 1);
    wr(8'h48, REL);
    cyc(LOCK + 1);
    chk("R7 relock", 8'h5C, 32'h20);
    cyc(1);
    chk("R8 ready one edge after lock", 8'h5C, 32'h24);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule